// File: doc/BRIEF.md
# Slot Hotplug Event Controller

This block tracks a small set of hot-pluggable slots and exposes them to software through a byte-wide register file. Register 0 is an event descriptor. Registers 1 to N each report one slot as present or empty. The host side issues add and remove requests, each carrying a slot index. An accepted request updates the descriptor and raises a one-cycle event toward a general-purpose event block. An add also marks the slot present and pulses that slot's power-on line.

Software finishes a removal by writing an eject command into the slot's register. The eject marks the slot empty, clears the descriptor and pulses that slot's power-off line. Requests that name a slot outside the hot-pluggable range are rejected: they change no state, and a reject pulse tells the host side that the request failed. Register reads are combinational. All state changes take effect at the clock edge that samples the request or the write. The pulse outputs are registered and high for the single cycle after that edge.

Top module: `hpc_slot_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the descriptor becomes 0x00, slot k is marked present exactly when present_init[k] is 1, and every pulse output becomes 0.
- R2: Register 0 reads as the descriptor. Bits 7:4 hold the slot index plus one, so 0 means no event. Bits 3:0 hold 0x0 for an add and 0x3 for a remove. An in-range add of slot s sets the descriptor to (s+1)<<4.
- R3: An in-range add of slot s makes register s+1 read 0x0F and drives slot_pwr_on with only bit s set, for one cycle.
- R4: An in-range remove of slot s sets the descriptor to ((s+1)<<4)|0x3 and leaves the status of slot s unchanged.
- R5: Each accepted add or remove drives gpe_event high for exactly the one cycle after the sampling edge.
- R6: Writing 0x01 to register k, with 1 <= k <= NUM_SLOTS, makes register k read 0x00, clears the descriptor to 0x00 and drives slot_pwr_off with only bit k-1 set, for one cycle.
- R7: A write of any value other than 0x01 to a slot register, any write to register 0 and any write above register NUM_SLOTS change no state and pulse nothing.
- R8: An add or remove whose slot index is NUM_SLOTS or more changes no state, raises no event and no power pulse, and drives req_reject high for one cycle.
- R9: When add_req and rem_req are both high in one cycle, only the add is carried out.
- R10: Reads of addresses above NUM_SLOTS return 0x00, and a slot register reads 0x0F for present and 0x00 for empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| present_init | input | NUM_SLOTS | Presence of each slot, loaded during reset |
| add_req | input | 1 | Host request to add a device in slot req_slot |
| rem_req | input | 1 | Host request to remove the device in slot req_slot |
| req_slot | input | SLOT_W | Slot index of the host request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| slot_pwr_on | output | NUM_SLOTS | One-cycle power-on pulse per slot |
| slot_pwr_off | output | NUM_SLOTS | One-cycle power-off pulse per slot |
| gpe_event | output | 1 | One-cycle hotplug event toward the event block |
| req_reject | output | 1 | One-cycle pulse for an out-of-range request |

## Verification
A corrupted descriptor shows on a register 0 read in the cycle right after the edge that updated it, because reads are combinational. A wrong presence bit shows on the matching slot register read just as quickly. A missing, doubled or misrouted power or event pulse appears on the pulse outputs in the cycle after the sampling edge, and a stuck pulse appears in the cycle after that. The bench therefore reads the descriptor and the slot registers after every stimulus and checks each pulse both when it is due and one cycle later.

// File: rtl/hpc_slot_ctrl.sv
module hpc_slot_ctrl #(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS) + 1,
  localparam int ADDR_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] present_init,
  input  logic                 add_req,
  input  logic                 rem_req,
  input  logic [SLOT_W-1:0]    req_slot,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  output logic [NUM_SLOTS-1:0] slot_pwr_on,
  output logic [NUM_SLOTS-1:0] slot_pwr_off,
  output logic                 gpe_event,
  output logic                 req_reject
);

  logic [NUM_SLOTS-1:0] present;
  logic [7:0]           desc;

  wire in_range = req_slot < SLOT_W'(NUM_SLOTS);
  wire do_add   = add_req & in_range;
  wire do_rem   = rem_req & ~add_req & in_range;
  wire bad_req  = (add_req | rem_req) & ~in_range;
  wire [3:0] tag = 4'(req_slot + 1'b1);

  wire              slot_reg = (reg_addr != '0) && (reg_addr <= ADDR_W'(NUM_SLOTS));
  wire [ADDR_W-1:0] sel      = reg_addr - 1'b1;
  wire              eject    = reg_wr & slot_reg & (reg_wdata == 8'h01);

  wire [NUM_SLOTS-1:0] add_vec = do_add ? (NUM_SLOTS'(1) << req_slot) : '0;
  wire [NUM_SLOTS-1:0] ej_vec  = eject  ? (NUM_SLOTS'(1) << sel)      : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      present      <= present_init;
      desc         <= 8'h00;
      slot_pwr_on  <= '0;
      slot_pwr_off <= '0;
      gpe_event    <= 1'b0;
      req_reject   <= 1'b0;
    end else begin
      present <= (present & ~ej_vec) | add_vec;
      if (do_add)      desc <= {tag, 4'h0};
      else if (do_rem) desc <= {tag, 4'h3};
      else if (eject)  desc <= 8'h00;
      slot_pwr_on  <= add_vec;
      slot_pwr_off <= ej_vec;
      gpe_event    <= do_add | do_rem;
      req_reject   <= bad_req;
    end
  end

  always_comb begin
    if (reg_addr == '0)  reg_rdata = desc;
    else if (slot_reg)   reg_rdata = {4'h0, {4{present[sel]}}};
    else                 reg_rdata = 8'h00;
  end

endmodule

module hpc_slot_ctrl_chk #(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 add_req,
  input logic                 rem_req,
  input logic [SLOT_W-1:0]    req_slot,
  input logic [NUM_SLOTS-1:0] slot_pwr_on,
  input logic [NUM_SLOTS-1:0] slot_pwr_off,
  input logic                 gpe_event,
  input logic                 req_reject,
  input logic [7:0]           desc
);

  wire req_ok = req_slot < SLOT_W'(NUM_SLOTS);

  assert_pwr_on_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_pwr_on));

  assert_pwr_off_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_pwr_off));

  assert_add_desc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (add_req && req_ok) |=> (desc[3:0] == 4'h0 && desc[7:4] != 4'h0));

  assert_rem_desc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_req && !add_req && req_ok) |=> (desc[3:0] == 4'h3));

  assert_event_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gpe_event |-> $past(add_req || rem_req));

  assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((add_req || rem_req) && !req_ok) |=> (req_reject && !gpe_event && slot_pwr_on == '0));

  assert_reject_stable_desc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (add_req || rem_req) && !req_ok) |=> $stable(desc));

  assert_add_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (add_req && rem_req && req_ok) |=> (desc[3:0] == 4'h0 && slot_pwr_on != '0));

endmodule

bind hpc_slot_ctrl hpc_slot_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .add_req(add_req), .rem_req(rem_req),
  .req_slot(req_slot), .slot_pwr_on(slot_pwr_on), .slot_pwr_off(slot_pwr_off),
  .gpe_event(gpe_event), .req_reject(req_reject), .desc(desc)
);

// File: tb/hpc_slot_ctrl_tb.sv
module hpc_slot_ctrl_tb;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [N-1:0] present_init = 8'b0000_0101;
  logic       add_req = 1'b0, rem_req = 1'b0, reg_wr = 1'b0;
  logic [3:0] req_slot = '0, reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] slot_pwr_on, slot_pwr_off;
  logic       gpe_event, req_reject;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hpc_slot_ctrl #(.NUM_SLOTS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .present_init(present_init),
    .add_req(add_req), .rem_req(rem_req), .req_slot(req_slot),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .slot_pwr_on(slot_pwr_on), .slot_pwr_off(slot_pwr_off),
    .gpe_event(gpe_event), .req_reject(req_reject)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // kind: 0 add, 1 remove, 2 write; {kind, slot/addr, wdata, exp_desc, exp_evt, exp_rej}
  localparam logic [25:0] VEC [10] = '{
    {4'd0, 4'd3,  8'h00, 8'h40, 1'b1, 1'b0},
    {4'd1, 4'd2,  8'h00, 8'h33, 1'b1, 1'b0},
    {4'd2, 4'd0,  8'hFF, 8'h33, 1'b0, 1'b0},
    {4'd2, 4'd3,  8'h02, 8'h33, 1'b0, 1'b0},
    {4'd2, 4'd3,  8'h01, 8'h00, 1'b0, 1'b0},
    {4'd0, 4'd9,  8'h00, 8'h00, 1'b0, 1'b1},
    {4'd1, 4'd15, 8'h00, 8'h00, 1'b0, 1'b1},
    {4'd0, 4'd7,  8'h00, 8'h80, 1'b1, 1'b0},
    {4'd1, 4'd0,  8'h00, 8'h13, 1'b1, 1'b0},
    {4'd2, 4'd12, 8'h01, 8'h13, 1'b0, 1'b0}
  };

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [N-1:0] exp_on, exp_off;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, d); chk("R1 desc", d, 8'h00);
    rd(4'd1, d); chk("R1 slot0 present", d, 8'h0F);
    rd(4'd2, d); chk("R1 slot1 empty", d, 8'h00);
    rd(4'd3, d); chk("R1 slot2 present", d, 8'h0F);
    chk("R1 pulses", {slot_pwr_on, slot_pwr_off, gpe_event, req_reject}, '0);

    for (int i = 0; i < 10; i++) begin
      logic [3:0] kind, a;
      logic [7:0] wd;
      {kind, a, wd} = VEC[i][25:10];
      @(negedge clk);
      add_req  = (kind == 4'd0);
      rem_req  = (kind == 4'd1);
      req_slot = a;
      reg_wr   = (kind == 4'd2);
      reg_addr = a;
      reg_wdata = wd;
      exp_on  = (kind == 4'd0 && a < N) ? (N'(1) << a) : '0;
      exp_off = (kind == 4'd2 && a >= 1 && a <= N && wd == 8'h01) ? (N'(1) << (a - 1)) : '0;
      @(negedge clk);
      add_req = 1'b0; rem_req = 1'b0; reg_wr = 1'b0;
      chk("R5 R8 event", {31'd0, gpe_event}, {31'd0, VEC[i][1]});
      chk("R8 reject", {31'd0, req_reject}, {31'd0, VEC[i][0]});
      chk("R3 pwr_on", slot_pwr_on, exp_on);
      chk("R6 R7 pwr_off", slot_pwr_off, exp_off);
      rd(4'd0, d);
      chk("R2 R4 R6 R7 R8 descriptor", d, VEC[i][9:2]);
      @(negedge clk);
      chk("R5 pulses one cycle", {slot_pwr_on, slot_pwr_off, gpe_event, req_reject}, '0);
    end

    // R4 remove keeps status present
    @(negedge clk); rem_req = 1'b1; req_slot = 4'd3;
    @(negedge clk); rem_req = 1'b0;
    rd(4'd4, d); chk("R4 slot3 still present", d, 8'h0F);
    rd(4'd0, d); chk("R4 descriptor", d, 8'h43);

    // R9 simultaneous add and remove
    @(negedge clk); add_req = 1'b1; rem_req = 1'b1; req_slot = 4'd5;
    @(negedge clk); add_req = 1'b0; rem_req = 1'b0;
    chk("R9 pwr_on", slot_pwr_on, 8'b0010_0000);
    chk("R9 single event", {31'd0, gpe_event}, 32'd1);
    rd(4'd0, d); chk("R9 descriptor add", d, 8'h60);
    rd(4'd6, d); chk("R9 slot5 present", d, 8'h0F);

    // R10 final slot statuses and out-of-range reads
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] expv;
      expv = 8'b1010_1001;
      rd(4'(k + 1), d);
      chk("R10 R6 slot status", d, expv[k] ? 8'h0F : 8'h00);
    end
    for (int a = N + 1; a < 16; a++) begin
      rd(4'(a), d); chk("R10 unmapped read", d, 8'h00);
    end

    // R1 reset reloads presence
    @(negedge clk); present_init = 8'b1000_0000; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(4'd0, d); chk("R1 desc after reset", d, 8'h00);
    rd(4'd1, d); chk("R1 slot0 after reset", d, 8'h00);
    rd(4'd8, d); chk("R1 slot7 after reset", d, 8'h0F);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule